// File: doc/BRIEF.md
# Shared Serial Flash Access Controller

This block sits between an external four-wire serial flash and three parties that want it: software, one other on-chip hardware agent, and an internal erase and status engine. Software asks for the flash by raising a request bit and waits for its grant bit. While it holds the grant, it drives the flash clock, chip select and data-out pins from register bits and reads the data-in pin back. Dropping the request releases the flash.

The block also keeps a two-bit write-enable field, an erase bit and a programmable erase opcode. Setting the erase bit and then writing zero into the write-enable field launches a whole-chip erase. The engine waits for the flash to be free. It then sends a write-enable frame, the erase opcode frame and repeated read-status frames until the flash's write-in-progress bit clears. After software writes one byte, it pulses a byte-written input. The engine then polls status inside the software tenancy, and busy stays set until the flash is done. A write-enable value of 10b blocks both paths.

All pins are plain control and status signals. No data path here carries a valid/ready handshake, so there is no back-pressure.

Top module: `sflash_share_ctrl`

## Requirements
- R1: After reset, all grants are 0, busy is 0, the erase bit is 0, the write-enable field reads 10b (writes disabled), and the flash pins idle with chip select high and clock low.
- R2: When the flash is free, a software request gives `sw_gnt_o` = 1 one cycle after the edge that owner logic sees it. Grant stays 0 while the hardware agent holds the flash. Once software drops the request, grant is 0 after the next edge.
- R3: If the hardware agent and software request in the same cycle, the hardware agent wins. A grant already given is never taken away while its request stays high. At most one grant is high at a time.
- R4: While software holds the grant and no engine frame is running, the flash clock, chip select and data-out pins follow `sw_sck_i`, `sw_cs_n_i` and `sw_mosi_i`. With no owner, chip select is 1 and clock is 0.
- R5: While the write-enable field is 10b, `erase_set_i` does not set the erase bit and `byte_wr_i` does not set busy or send any frame.
- R6: A `byte_wr_i` pulse while software holds the grant, writes are enabled and busy is clear sets busy on the next edge. The block then sends read-status frames (opcode 05h, then 8 read bits) until bit 0 of the returned status is 0. Busy then clears and the grant is kept.
- R7: With the erase bit set and busy clear, a write of 00b to the write-enable field sets busy. The block then sends a frame of 06h, then a frame holding the erase opcode, then 05h status frames until bit 0 reads 0. At that point both busy and the erase bit clear by themselves.
- R8: The erase frame carries the value last written through `op_we_i`/`op_d_i`. The reset value is C7h.
- R9: A pending erase never takes the flash from a software tenancy. When the flash becomes free, the erase engine wins over the hardware agent.
- R10: Engine frames are mode 0 and MSB first. Data is stable while the clock rises, the clock idles low, and chip select goes high for at least one cycle between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_req_i | input | 1 | Software request bit |
| sw_gnt_o | output | 1 | Software grant bit |
| hw_req_i | input | 1 | Hardware agent request |
| hw_gnt_o | output | 1 | Hardware agent grant |
| hw_sck_i | input | 1 | Hardware agent flash clock |
| hw_cs_n_i | input | 1 | Hardware agent chip select, active low |
| hw_mosi_i | input | 1 | Hardware agent data to flash |
| hw_miso_o | output | 1 | Flash data to hardware agent, 0 when not granted |
| sw_sck_i | input | 1 | Software clock bit |
| sw_cs_n_i | input | 1 | Software chip-select bit |
| sw_mosi_i | input | 1 | Software data-out bit |
| sw_miso_o | output | 1 | Flash data-in bit for software, 0 when not granted |
| wen_we_i | input | 1 | Write strobe for the write-enable field |
| wen_d_i | input | 2 | New write-enable value (10b = disabled) |
| wen_o | output | 2 | Current write-enable field |
| erase_set_i | input | 1 | Pulse that sets the erase bit |
| erase_o | output | 1 | Erase bit |
| op_we_i | input | 1 | Write strobe for the erase opcode |
| op_d_i | input | 8 | New erase opcode |
| byte_wr_i | input | 1 | Pulse: software has finished sending one byte write |
| busy_o | output | 1 | Write or erase in progress |
| fl_sck_o | output | 1 | Flash clock |
| fl_cs_n_o | output | 1 | Flash chip select, active low |
| fl_mosi_o | output | 1 | Data to flash |
| fl_miso_i | input | 1 | Data from flash |

## Verification
The bench targets arbitration in three cases: simultaneous requests, a hardware request that arrives during a software tenancy, and an erase pending while software holds the flash. A design that preempts, or that lets the hardware agent in ahead of the engine, shows the wrong grant bit or an unexpected frame. A flash model decodes every frame from the pins and compares it with an expected-opcode queue. That comparison exposes a wrong bit order, a hard-coded erase opcode, a missing write-enable frame, or a status poll that stops one read early or too late. The write-disabled case confirms that the erase bit, busy and the pins stay untouched when the field reads 10b.

// File: rtl/sflash_pkg.sv
package sflash_pkg;
  localparam int OP_W = 8;
  localparam int WEN_W = 2;
  localparam logic [WEN_W-1:0] WEN_OFF = 2'b10;
  localparam logic [OP_W-1:0] OP_WREN = 8'h06;
  localparam logic [OP_W-1:0] OP_RDSR = 8'h05;

  typedef enum logic [1:0] {OWN_NONE, OWN_ENG, OWN_HW, OWN_SW} owner_e;
  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_WREN, S_ERASE, S_POLL} seq_e;
endpackage

// File: rtl/sflash_arb.sv
module sflash_arb
  import sflash_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic eng_req_i,
  input  logic hw_req_i,
  input  logic sw_req_i,
  output logic eng_gnt_o,
  output logic hw_gnt_o,
  output logic sw_gnt_o
);
  owner_e owner_q;

  always_ff @(posedge clk) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else begin
      unique case (owner_q)
        OWN_NONE: begin
          if (eng_req_i)     owner_q <= OWN_ENG;
          else if (hw_req_i) owner_q <= OWN_HW;
          else if (sw_req_i) owner_q <= OWN_SW;
        end
        OWN_ENG: if (!eng_req_i) owner_q <= OWN_NONE;
        OWN_HW:  if (!hw_req_i)  owner_q <= OWN_NONE;
        OWN_SW:  if (!sw_req_i)  owner_q <= OWN_NONE;
        default: owner_q <= OWN_NONE;
      endcase
    end
  end

  assign eng_gnt_o = (owner_q == OWN_ENG);
  assign hw_gnt_o  = (owner_q == OWN_HW);
  assign sw_gnt_o  = (owner_q == OWN_SW);

  p_onehot_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eng_gnt_o, hw_gnt_o, sw_gnt_o}));
  p_no_preempt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_gnt_o && sw_req_i) |=> sw_gnt_o);
  p_hw_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_gnt_o && !hw_gnt_o && !sw_gnt_o && hw_req_i && sw_req_i && !eng_req_i) |=> hw_gnt_o);
endmodule

// File: rtl/sflash_shifter.sv
module sflash_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] byte_i,
  input  logic         rd_i,
  input  logic         miso_i,
  output logic         sck_o,
  output logic         cs_n_o,
  output logic         mosi_o,
  output logic         done_o,
  output logic [W-1:0] rx_o
);
  localparam int CW = $clog2(2 * W) + 1;

  logic          act_q, ph_q, sck_q, cs_n_q, done_q;
  logic [W-1:0]  sh_q, rx_q;
  logic [CW-1:0] cnt_q, last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0; ph_q <= 1'b0; sck_q <= 1'b0; cs_n_q <= 1'b1;
      done_q <= 1'b0; sh_q <= '0; rx_q <= '0; cnt_q <= '0; last_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !act_q) begin
        act_q  <= 1'b1;
        cs_n_q <= 1'b0;
        sck_q  <= 1'b0;
        ph_q   <= 1'b0;
        sh_q   <= byte_i;
        cnt_q  <= '0;
        last_q <= rd_i ? CW'(2 * W - 1) : CW'(W - 1);
      end else if (act_q) begin
        if (!ph_q) begin
          sck_q <= 1'b1;
          ph_q  <= 1'b1;
        end else begin
          sck_q <= 1'b0;
          ph_q  <= 1'b0;
          rx_q  <= {rx_q[W-2:0], miso_i};
          sh_q  <= {sh_q[W-2:0], 1'b0};
          if (cnt_q == last_q) begin
            act_q  <= 1'b0;
            cs_n_q <= 1'b1;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign sck_o  = sck_q;
  assign cs_n_o = cs_n_q;
  assign mosi_o = sh_q[W-1];
  assign done_o = done_q;
  assign rx_o   = rx_q;

  p_sck_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> !sck_q);
  p_cs_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> cs_n_q);
endmodule

// File: rtl/sflash_seq.sv
module sflash_seq
  import sflash_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            erase_go_i,
  input  logic            poll_go_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            gnt_i,
  input  logic            done_i,
  input  logic [OP_W-1:0] rx_i,
  output logic            start_o,
  output logic [OP_W-1:0] byte_o,
  output logic            rd_o,
  output logic            req_o,
  output logic            drive_o,
  output logic            hold_o,
  output logic            fin_o
);
  seq_e st_q;
  logic ers_q, start_q, rd_q, fin_q;
  logic [OP_W-1:0] byte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE; ers_q <= 1'b0; start_q <= 1'b0;
      rd_q <= 1'b0; fin_q <= 1'b0; byte_q <= '0;
    end else begin
      start_q <= 1'b0;
      fin_q   <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (erase_go_i) begin
            ers_q <= 1'b1;
            st_q  <= S_WAIT;
          end else if (poll_go_i) begin
            ers_q <= 1'b0;
            st_q  <= S_POLL;
            start_q <= 1'b1; byte_q <= OP_RDSR; rd_q <= 1'b1;
          end
        end
        S_WAIT: if (gnt_i) begin
          st_q <= S_WREN;
          start_q <= 1'b1; byte_q <= OP_WREN; rd_q <= 1'b0;
        end
        S_WREN: if (done_i) begin
          st_q <= S_ERASE;
          start_q <= 1'b1; byte_q <= op_i; rd_q <= 1'b0;
        end
        S_ERASE: if (done_i) begin
          st_q <= S_POLL;
          start_q <= 1'b1; byte_q <= OP_RDSR; rd_q <= 1'b1;
        end
        S_POLL: if (done_i) begin
          if (rx_i[0]) begin
            start_q <= 1'b1; byte_q <= OP_RDSR; rd_q <= 1'b1;
          end else begin
            st_q  <= S_IDLE;
            ers_q <= 1'b0;
            fin_q <= 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign start_o = start_q;
  assign byte_o  = byte_q;
  assign rd_o    = rd_q;
  assign req_o   = ers_q && (st_q != S_IDLE);
  assign drive_o = (st_q == S_WREN) || (st_q == S_ERASE) || (st_q == S_POLL);
  assign hold_o  = drive_o && !ers_q;
  assign fin_o   = fin_q;

  p_erase_needs_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == S_WAIT && st_q == S_WREN) |-> $past(gnt_i));
endmodule

// File: rtl/sflash_share_ctrl.sv
module sflash_share_ctrl
  import sflash_pkg::*;
#(
  parameter logic [7:0] ERASE_OP_RST = 8'hC7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_req_i,
  output logic       sw_gnt_o,
  input  logic       hw_req_i,
  output logic       hw_gnt_o,
  input  logic       hw_sck_i,
  input  logic       hw_cs_n_i,
  input  logic       hw_mosi_i,
  output logic       hw_miso_o,
  input  logic       sw_sck_i,
  input  logic       sw_cs_n_i,
  input  logic       sw_mosi_i,
  output logic       sw_miso_o,
  input  logic       wen_we_i,
  input  logic [1:0] wen_d_i,
  output logic [1:0] wen_o,
  input  logic       erase_set_i,
  output logic       erase_o,
  input  logic       op_we_i,
  input  logic [7:0] op_d_i,
  input  logic       byte_wr_i,
  output logic       busy_o,
  output logic       fl_sck_o,
  output logic       fl_cs_n_o,
  output logic       fl_mosi_o,
  input  logic       fl_miso_i
);
  logic [WEN_W-1:0] wen_q;
  logic [OP_W-1:0]  op_q, sh_byte, rx;
  logic erase_q, busy_q;
  logic eng_req, eng_gnt, eng_drive, eng_hold, eng_fin;
  logic sh_start, sh_rd, sh_done, sh_sck, sh_cs_n, sh_mosi;
  logic wr_ok, erase_go, poll_go;

  assign wr_ok    = (wen_q != WEN_OFF);
  assign erase_go = erase_q && wen_we_i && (wen_d_i == '0) && !busy_q;
  assign poll_go  = byte_wr_i && sw_gnt_o && wr_ok && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wen_q <= WEN_OFF; op_q <= ERASE_OP_RST; erase_q <= 1'b0; busy_q <= 1'b0;
    end else begin
      if (op_we_i) op_q <= op_d_i;
      if (erase_go || poll_go) busy_q <= 1'b1;
      if (erase_set_i && wr_ok && !busy_q) erase_q <= 1'b1;
      if (wen_we_i) begin
        wen_q <= wen_d_i;
        if (wen_d_i == WEN_OFF) erase_q <= 1'b0;
      end
      if (eng_fin) begin
        busy_q  <= 1'b0;
        erase_q <= 1'b0;
      end
    end
  end

  sflash_arb u_arb (
    .clk(clk), .rst_n(rst_n),
    .eng_req_i(eng_req), .hw_req_i(hw_req_i), .sw_req_i(sw_req_i || eng_hold),
    .eng_gnt_o(eng_gnt), .hw_gnt_o(hw_gnt_o), .sw_gnt_o(sw_gnt_o)
  );

  sflash_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .erase_go_i(erase_go), .poll_go_i(poll_go), .op_i(op_q),
    .gnt_i(eng_gnt), .done_i(sh_done), .rx_i(rx),
    .start_o(sh_start), .byte_o(sh_byte), .rd_o(sh_rd),
    .req_o(eng_req), .drive_o(eng_drive), .hold_o(eng_hold), .fin_o(eng_fin)
  );

  sflash_shifter #(.W(OP_W)) u_sh (
    .clk(clk), .rst_n(rst_n),
    .start_i(sh_start), .byte_i(sh_byte), .rd_i(sh_rd), .miso_i(fl_miso_i),
    .sck_o(sh_sck), .cs_n_o(sh_cs_n), .mosi_o(sh_mosi), .done_o(sh_done), .rx_o(rx)
  );

  always_comb begin
    fl_sck_o = 1'b0; fl_cs_n_o = 1'b1; fl_mosi_o = 1'b0;
    if (eng_drive) begin
      fl_sck_o = sh_sck; fl_cs_n_o = sh_cs_n; fl_mosi_o = sh_mosi;
    end else if (sw_gnt_o) begin
      fl_sck_o = sw_sck_i; fl_cs_n_o = sw_cs_n_i; fl_mosi_o = sw_mosi_i;
    end else if (hw_gnt_o) begin
      fl_sck_o = hw_sck_i; fl_cs_n_o = hw_cs_n_i; fl_mosi_o = hw_mosi_i;
    end
  end

  assign sw_miso_o = sw_gnt_o && fl_miso_i;
  assign hw_miso_o = hw_gnt_o && fl_miso_i;
  assign wen_o     = wen_q;
  assign erase_o   = erase_q;
  assign busy_o    = busy_q;

  p_wp_no_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_q == WEN_OFF && !busy_q) |=> !busy_q);
  p_wp_no_erase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_q == WEN_OFF && !erase_q && !wen_we_i) |=> !erase_q);
  p_fin_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_fin |=> (!busy_o && !erase_o));
  p_busy_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(byte_wr_i || wen_we_i));
endmodule

// File: tb/sflash_share_ctrl_test.sv
module sflash_share_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_req = 0, hw_req = 0, hw_sck = 0, hw_cs_n = 1, hw_mosi = 0;
  logic sw_sck = 0, sw_cs_n = 1, sw_mosi = 0;
  logic wen_we = 0, erase_set = 0, op_we = 0, byte_wr = 0;
  logic [1:0] wen_d = 0;
  logic [7:0] op_d = 0;
  logic sw_gnt, hw_gnt, hw_miso, sw_miso, erase_o, busy;
  logic [1:0] wen_o;
  logic fl_sck, fl_cs_n, fl_mosi;
  logic m_miso = 1'b0;

  int checks = 0, failures = 0;
  bit finished = 0;
  int frames = 0, polls = 0, wip_left = 0, m_bits = 0;
  logic [7:0] m_sh = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  sflash_share_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .sw_req_i(sw_req), .sw_gnt_o(sw_gnt),
    .hw_req_i(hw_req), .hw_gnt_o(hw_gnt),
    .hw_sck_i(hw_sck), .hw_cs_n_i(hw_cs_n), .hw_mosi_i(hw_mosi), .hw_miso_o(hw_miso),
    .sw_sck_i(sw_sck), .sw_cs_n_i(sw_cs_n), .sw_mosi_i(sw_mosi), .sw_miso_o(sw_miso),
    .wen_we_i(wen_we), .wen_d_i(wen_d), .wen_o(wen_o),
    .erase_set_i(erase_set), .erase_o(erase_o),
    .op_we_i(op_we), .op_d_i(op_d),
    .byte_wr_i(byte_wr), .busy_o(busy),
    .fl_sck_o(fl_sck), .fl_cs_n_o(fl_cs_n), .fl_mosi_o(fl_mosi), .fl_miso_i(m_miso)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // flash model (mode 0, MSB first), status bit 0 = write in progress
  always @(negedge fl_cs_n or posedge fl_sck) begin
    if (!fl_cs_n && !fl_sck) begin
      m_bits = 0; m_sh = 8'h00;
    end else if (!fl_cs_n && fl_sck) begin
      if (m_bits < 8) m_sh = {m_sh[6:0], fl_mosi};
      m_bits++;
    end
  end
  always @(negedge fl_sck)
    if (!fl_cs_n && m_bits >= 8) m_miso = (m_bits == 15) ? (wip_left > 0) : 1'b0;

  // scoreboard monitor
  always @(posedge fl_cs_n) begin
    if (m_bits >= 8) begin
      frames++;
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10 unexpected frame actual=%0h expected=none", m_sh);
      end else chk("R10 frame opcode", {24'h0, m_sh}, {24'h0, exp_q.pop_front()});
      if (m_sh == 8'h05) begin
        polls++;
        if (wip_left > 0) wip_left--;
      end
    end
  end

  task automatic push(input logic [7:0] b); exp_q.push_back(b); endtask
  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask

  task automatic sw_frame(input logic [7:0] b);
    push(b);
    @(negedge clk) sw_cs_n = 0;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) begin sw_mosi = b[i]; sw_sck = 0; end
      @(negedge clk) sw_sck = 1;
    end
    @(negedge clk) sw_sck = 0;
    @(negedge clk) sw_cs_n = 1;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
    chk(req, {31'h0, busy}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int f0;
    cyc(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sw_gnt", {31'h0, sw_gnt}, 0);
    chk("R1 hw_gnt", {31'h0, hw_gnt}, 0);
    chk("R1 busy", {31'h0, busy}, 0);
    chk("R1 erase", {31'h0, erase_o}, 0);
    chk("R1 wen", {30'h0, wen_o}, 32'h2);
    chk("R1 cs_n", {31'h0, fl_cs_n}, 1);
    chk("R1 sck", {31'h0, fl_sck}, 0);

    // R3 simultaneous request: hardware agent wins
    hw_req = 1; sw_req = 1;
    @(negedge clk);
    chk("R3 hw wins", {31'h0, hw_gnt}, 1);
    chk("R3 sw loses", {31'h0, sw_gnt}, 0);
    cyc(5);
    chk("R2 sw held off", {31'h0, sw_gnt}, 0);
    hw_req = 0;
    cyc(2);
    chk("R2 sw granted after release", {31'h0, sw_gnt}, 1);
    hw_req = 1;
    cyc(4);
    chk("R3 no preempt sw", {31'h0, sw_gnt}, 1);
    chk("R3 no preempt hw", {31'h0, hw_gnt}, 0);
    hw_req = 0;

    // R4 pin passthrough
    sw_cs_n = 0; sw_sck = 1; sw_mosi = 1;
    #1;
    chk("R4 pins follow sw", {29'h0, fl_cs_n, fl_sck, fl_mosi}, 32'h3);
    sw_sck = 0; sw_cs_n = 1; sw_mosi = 0;
    sw_frame(8'h9F);
    sw_req = 0;
    @(negedge clk);
    chk("R2 grant drops", {31'h0, sw_gnt}, 0);
    sw_cs_n = 0; sw_sck = 1;
    cyc(2);
    chk("R4 idle pins", {30'h0, fl_cs_n, fl_sck}, 32'h2);
    sw_cs_n = 1; sw_sck = 0;

    // R5 write disabled: erase bit and byte write ignored
    erase_set = 1; @(negedge clk); erase_set = 0;
    @(negedge clk);
    chk("R5 erase bit blocked", {31'h0, erase_o}, 0);
    sw_req = 1; cyc(2);
    f0 = frames;
    byte_wr = 1; @(negedge clk); byte_wr = 0;
    cyc(40);
    chk("R5 busy blocked", {31'h0, busy}, 0);
    chk("R5 no frames", frames - f0, 0);

    // R6 byte write then status polling
    wen_we = 1; wen_d = 2'b01; @(negedge clk); wen_we = 0;
    sw_frame(8'h02);
    wip_left = 3; polls = 0;
    for (int i = 0; i < 4; i++) push(8'h05);
    byte_wr = 1; @(negedge clk); byte_wr = 0;
    chk("R6 busy set", {31'h0, busy}, 1);
    wait_idle("R6 busy clears");
    chk("R6 poll count", polls, 4);
    chk("R6 queue drained", exp_q.size(), 0);
    chk("R6 grant kept", {31'h0, sw_gnt}, 1);

    // R7/R8/R9 chip erase with programmed opcode while software holds flash
    op_we = 1; op_d = 8'h60; @(negedge clk); op_we = 0;
    erase_set = 1; @(negedge clk); erase_set = 0;
    chk("R7 erase bit set", {31'h0, erase_o}, 1);
    wen_we = 1; wen_d = 2'b00; @(negedge clk); wen_we = 0;
    chk("R7 busy on launch", {31'h0, busy}, 1);
    hw_req = 1;
    f0 = frames;
    cyc(30);
    chk("R9 no frame during sw tenancy", frames - f0, 0);
    chk("R9 sw keeps grant", {31'h0, sw_gnt}, 1);
    wip_left = 2; polls = 0;
    push(8'h06); push(8'h60); push(8'h05); push(8'h05); push(8'h05);
    sw_req = 0;
    cyc(4);
    chk("R9 engine beats hw", {31'h0, hw_gnt}, 0);
    wait_idle("R7 busy clears");
    chk("R7 erase bit self-clears", {31'h0, erase_o}, 0);
    chk("R8 queue drained", exp_q.size(), 0);
    chk("R7 poll count", polls, 3);
    cyc(3);
    chk("R9 hw granted after erase", {31'h0, hw_gnt}, 1);
    hw_req = 0;
    cyc(3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule